// File: doc/BRIEF.md
# Byte ALU with Zero and Carry Flags

This block is the combinational datapath unit of a small 8-bit processor core, together with the two-bit flag register that sits behind it. It takes a first operand and a second operand. The second operand is chosen either from a register value or from an immediate value. It also takes a four-bit function select and a three-bit literal shift count. From these it produces an 8-bit result and the next values of the zero (Z) and carry (C) flags. The flag register stores those next values on a clock edge when the flag-update enable is high. The stored C is fed back as the carry or borrow input of the carry-using arithmetic variants.

The meaning of C depends on the operation class:

- Arithmetic operations put the carry or borrow in C.
- Bitwise logic operations clear C.
- Shifts and rotates put the last bit that left the byte in C.

A fourth class covers load, store, input and output instructions. For that class the unit passes the selected second operand through and offers the stored flags unchanged as the next flags. Storing them back therefore has no effect.

Function select encoding: bits [3:2] pick the class (00 arithmetic, 01 logic, 10 shift, 11 pass/memory). Bits [1:0] pick the operation within the class.

Top module: `byte_alu`

## Requirements
- R1: With op 0000 (add) the result is (a + b) mod 256 and C is the carry out of bit 7. With op 0001 (add with carry) the stored C flag is added as well.
- R2: With op 0010 (subtract) the result is (a - b) mod 256 and C is 1 exactly when a < b. With op 0011 (subtract with borrow) the stored C is also subtracted, and C is 1 exactly when a < b + C.
- R3: Ops 0100, 0101, 0110 and 0111 give a AND b, a OR b, a XOR b, and a AND NOT b, all bitwise. Each of them gives C = 0.
- R4: Ops 1000, 1001, 1010 and 1011 with a count n from 1 to 7 give, in order: logical shift left, logical shift right, rotate left and rotate right of a by n. C is the last bit moved past the end of the byte: bit 8-n of a for a left shift or rotate, and bit n-1 of a for a right shift or rotate.
- R5: A shift or rotate with count 0 gives result = a, and the next C equals the stored C.
- R6: For every arithmetic, logic and shift op, the next Z is 1 exactly when the 8-bit result is zero.
- R7: For ops 1100 to 1111 (memory and I/O), the next Z and next C equal the stored flags, and the result equals the selected second operand.
- R8: The second operand is the immediate input when use_imm_i is 1 and the register input when it is 0.
- R9: The stored flags take the next-flag values at a rising clock edge only when flag_we_i is 1. Otherwise they keep their value.
- R10: An active-low reset, asynchronous, clears the stored Z and C to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Function select: class in [3:2], operation in [1:0] |
| a_i | input | 8 | First operand |
| b_reg_i | input | 8 | Second operand from a register |
| imm_i | input | 8 | Second operand from an immediate |
| use_imm_i | input | 1 | Selects the immediate as the second operand |
| shamt_i | input | 3 | Literal shift or rotate count |
| flag_we_i | input | 1 | Flag-update enable |
| result_o | output | 8 | Operation result |
| z_next_o | output | 1 | Next value of the zero flag |
| c_next_o | output | 1 | Next value of the carry flag |
| z_o | output | 1 | Stored zero flag |
| c_o | output | 1 | Stored carry flag |

## Verification
The only internal state is the stored flag pair. A wrong stored value shows up at z_o and c_o in the cycle after the faulty edge. When C is wrong, it also shows up at once in result_o and c_next_o, for the carry-using arithmetic ops and for zero-count shifts. It shows up as well in both next-flag outputs for the pass class. The bench therefore sweeps every operation over all first-operand values while both stored flag states are in place. This catches a corrupted or stale flag within the same combinational step that reads it.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
   typedef enum logic [1:0] {
      CLS_ARITH = 2'b00,
      CLS_LOGIC = 2'b01,
      CLS_SHIFT = 2'b10,
      CLS_PASS  = 2'b11
   } op_class_e;

   // sub-operation codes inside the shift class
   localparam logic [1:0] SH_LSL = 2'd0;
   localparam logic [1:0] SH_LSR = 2'd1;
   localparam logic [1:0] SH_ROL = 2'd2;
   localparam logic [1:0] SH_ROR = 2'd3;
endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [1:0]   fn_i,
   input  logic         cin_i,
   output logic [W-1:0] r_o,
   output logic         c_o,
   output logic         z_o
);
   logic         use_c;
   logic         is_sub;
   logic [W:0]   wide;

   assign is_sub = fn_i[1];
   assign use_c  = fn_i[0] & cin_i;

   always_comb begin
      if (is_sub)
         wide = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, use_c};
      else
         wide = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, use_c};
   end

   assign r_o = wide[W-1:0];
   assign c_o = wide[W];
   assign z_o = (wide[W-1:0] == '0);
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [1:0]   fn_i,
   output logic [W-1:0] r_o,
   output logic         z_o
);
   always_comb begin
      unique case (fn_i)
         2'd0:    r_o = a_i & b_i;
         2'd1:    r_o = a_i | b_i;
         2'd2:    r_o = a_i ^ b_i;
         default: r_o = a_i & ~b_i;
      endcase
   end

   assign z_o = (r_o == '0);
endmodule

// File: rtl/byte_alu_shift.sv
module byte_alu_shift
   import byte_alu_pkg::*;
#(
   parameter int W       = 8,
   parameter int VARIANT = 1,
   localparam int CW     = $clog2(W)
) (
   input  logic [W-1:0]  a_i,
   input  logic [CW-1:0] n_i,
   input  logic [1:0]    fn_i,
   input  logic          cin_i,
   output logic [W-1:0]  r_o,
   output logic          c_o,
   output logic          z_o
);
   logic [W-1:0] r_raw;
   logic         c_raw;

   if (VARIANT != 0 && VARIANT != 1) begin : g_bad_variant
      $error("byte_alu_shift: VARIANT must be 0 or 1");
   end

   if (VARIANT == 0) begin : g_indexed
      logic [CW-1:0] idx_l;
      logic [CW-1:0] idx_r;
      always_comb begin
         idx_l = CW'(W - int'(n_i));
         idx_r = n_i - 1'b1;
         unique case (fn_i)
            SH_LSL: begin r_raw = a_i << n_i; c_raw = a_i[idx_l]; end
            SH_LSR: begin r_raw = a_i >> n_i; c_raw = a_i[idx_r]; end
            SH_ROL: begin r_raw = (a_i << n_i) | (a_i >> idx_l); c_raw = a_i[idx_l]; end
            default: begin r_raw = (a_i >> n_i) | (a_i << idx_l); c_raw = a_i[idx_r]; end
         endcase
      end
   end else begin : g_wide
      logic [2*W-1:0] t;
      always_comb begin
         unique case (fn_i)
            SH_LSL: begin
               t = {{W{1'b0}}, a_i} << n_i;
               r_raw = t[W-1:0];
               c_raw = t[W];
            end
            SH_LSR: begin
               t = {a_i, {W{1'b0}}} >> n_i;
               r_raw = t[2*W-1:W];
               c_raw = t[W-1];
            end
            SH_ROL: begin
               t = {a_i, a_i} << n_i;
               r_raw = t[2*W-1:W];
               c_raw = t[W];
            end
            default: begin
               t = {a_i, a_i} >> n_i;
               r_raw = t[W-1:0];
               c_raw = t[W-1];
            end
         endcase
      end
   end

   // a zero count moves no bit out: operand passes, carry is retained
   assign r_o = (n_i == '0) ? a_i   : r_raw;
   assign c_o = (n_i == '0) ? cin_i : c_raw;
   assign z_o = (r_o == '0);
endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic we_i,
   input  logic z_d_i,
   input  logic c_d_i,
   output logic z_q_o,
   output logic c_q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         z_q_o <= 1'b0;
         c_q_o <= 1'b0;
      end else if (we_i) begin
         z_q_o <= z_d_i;
         c_q_o <= c_d_i;
      end
   end

   // R9
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable({z_q_o, c_q_o}));

   // R9
   flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> ({z_q_o, c_q_o} == $past({z_d_i, c_d_i})));
endmodule

// File: rtl/byte_alu.sv
module byte_alu
   import byte_alu_pkg::*;
#(
   parameter int W             = 8,
   parameter int SHIFT_VARIANT = 1,
   localparam int CW           = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    op_i,
   input  logic [W-1:0]  a_i,
   input  logic [W-1:0]  b_reg_i,
   input  logic [W-1:0]  imm_i,
   input  logic          use_imm_i,
   input  logic [CW-1:0] shamt_i,
   input  logic          flag_we_i,
   output logic [W-1:0]  result_o,
   output logic          z_next_o,
   output logic          c_next_o,
   output logic          z_o,
   output logic          c_o
);
   if (W < 2 || (W & (W - 1)) != 0) begin : g_bad_width
      $error("byte_alu: W must be a power of two of at least 2");
   end

   op_class_e    cls;
   logic [1:0]   fn;
   logic [W-1:0] b_sel;
   logic [W-1:0] r_ar, r_lg, r_sh;
   logic         c_ar, c_sh;
   logic         z_ar, z_lg, z_sh;

   assign cls   = op_class_e'(op_i[3:2]);
   assign fn    = op_i[1:0];
   assign b_sel = use_imm_i ? imm_i : b_reg_i;

   byte_alu_addsub #(.W(W)) u_addsub (
      .a_i(a_i), .b_i(b_sel), .fn_i(fn), .cin_i(c_o),
      .r_o(r_ar), .c_o(c_ar), .z_o(z_ar)
   );

   byte_alu_logic #(.W(W)) u_logic (
      .a_i(a_i), .b_i(b_sel), .fn_i(fn),
      .r_o(r_lg), .z_o(z_lg)
   );

   byte_alu_shift #(.W(W), .VARIANT(SHIFT_VARIANT)) u_shift (
      .a_i(a_i), .n_i(shamt_i), .fn_i(fn), .cin_i(c_o),
      .r_o(r_sh), .c_o(c_sh), .z_o(z_sh)
   );

   always_comb begin
      unique case (cls)
         CLS_ARITH: begin result_o = r_ar;  z_next_o = z_ar; c_next_o = c_ar; end
         CLS_LOGIC: begin result_o = r_lg;  z_next_o = z_lg; c_next_o = 1'b0; end
         CLS_SHIFT: begin result_o = r_sh;  z_next_o = z_sh; c_next_o = c_sh; end
         default:   begin result_o = b_sel; z_next_o = z_o;  c_next_o = c_o;  end
      endcase
   end

   byte_alu_flags u_flags (
      .clk(clk), .rst_n(rst_n), .we_i(flag_we_i),
      .z_d_i(z_next_o), .c_d_i(c_next_o),
      .z_q_o(z_o), .c_q_o(c_o)
   );

   // R7
   pass_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == CLS_PASS) |-> (z_next_o == z_o && c_next_o == c_o));

   // R6
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cls != CLS_PASS) |-> (z_next_o == (result_o == '0)));

   // R3
   logic_carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == CLS_LOGIC) |-> !c_next_o);

   // R5
   zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == CLS_SHIFT && shamt_i == '0) |-> (c_next_o == c_o && result_o == a_i));
endmodule

// File: tb/tb_byte_alu.sv
module tb_byte_alu;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_i = '0;
   logic [7:0] a_i = '0, b_reg_i = '0, imm_i = '0;
   logic       use_imm_i = 1'b0;
   logic [2:0] shamt_i = '0;
   logic       flag_we_i = 1'b0;
   logic [7:0] result_o;
   logic       z_next_o, c_next_o, z_o, c_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   byte_alu dut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_reg_i(b_reg_i),
      .imm_i(imm_i), .use_imm_i(use_imm_i), .shamt_i(shamt_i),
      .flag_we_i(flag_we_i), .result_o(result_o), .z_next_o(z_next_o),
      .c_next_o(c_next_o), .z_o(z_o), .c_o(c_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (op=%0h a=%0d sh=%0d)",
                  req, what, act, exp, op_i, a_i, shamt_i);
      end
   endtask

   // expected {c, z, result} from the requirement text
   function automatic int model(input int op, input int a, input int b,
                                input int n, input int zin, input int cin);
      int r, c, v;
      int cls = op / 4;
      int f   = op % 4;
      case (cls)
         0: begin
            if (f < 2) begin
               v = a + b + ((f == 1) ? cin : 0);
               r = v % 256; c = (v >= 256) ? 1 : 0;
            end else begin
               v = a - b - ((f == 3) ? cin : 0);
               c = (v < 0) ? 1 : 0; r = (v + 512) % 256;
            end
         end
         1: begin
            case (f)
               0: r = a & b;
               1: r = a | b;
               2: r = a ^ b;
               default: r = a & (255 - b);
            endcase
            c = 0;
         end
         2: begin
            if (n == 0) begin r = a; c = cin; end
            else case (f)
               0: begin r = (a * (1 << n)) % 256; c = (a >> (8 - n)) & 1; end
               1: begin r = a >> n; c = (a >> (n - 1)) & 1; end
               2: begin r = ((a << n) | (a >> (8 - n))) & 255; c = (a >> (8 - n)) & 1; end
               default: begin r = ((a >> n) | (a << (8 - n))) & 255; c = (a >> (n - 1)) & 1; end
            endcase
         end
         default: return b + 256 * zin + 512 * cin;
      endcase
      return r + ((r == 0) ? 256 : 0) + 512 * c;
   endfunction

   task automatic load_flags(input int op, input int a, input int b);
      @(negedge clk);
      op_i = 4'(op); a_i = 8'(a); b_reg_i = 8'(b); use_imm_i = 1'b0;
      shamt_i = 3'd1; flag_we_i = 1'b1;
      @(negedge clk);
      flag_we_i = 1'b0;
      #1;
   endtask

   initial begin
      #(4 * 190000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10", "z_o after reset", int'(z_o), 0);
      check("R10", "c_o after reset", int'(c_o), 0);
      rst_n = 1'b1;

      // R9: load with enable (0x80+0x80 -> Z=1, C=1)
      load_flags(0, 8'h80, 8'h80);
      check("R9", "z_o loaded", int'(z_o), 1);
      check("R9", "c_o loaded", int'(c_o), 1);
      // R9: no enable -> flags stay though the op would clear them
      @(negedge clk);
      op_i = 4'b0101; a_i = 8'h01; b_reg_i = 8'h00; flag_we_i = 1'b0;
      @(negedge clk);
      check("R9", "z_o held", int'(z_o), 1);
      check("R9", "c_o held", int'(c_o), 1);

      // R8: operand mux on the pass class
      op_i = 4'b1100; b_reg_i = 8'h3C; imm_i = 8'hA5; use_imm_i = 1'b1; #1;
      check("R8", "imm selected", int'(result_o), 8'hA5);
      use_imm_i = 1'b0; #1;
      check("R8", "reg selected", int'(result_o), 8'h3C);

      // Sweep under both stored flag states: (Z=0,C=0) and (Z=1,C=1)
      for (int st = 0; st < 2; st++) begin
         if (st == 0) load_flags(4'b0101, 1, 0);
         else         load_flags(0, 8'h80, 8'h80);
         for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
               for (int k = 0; k < 8; k++) begin
                  int b, e;
                  string rq;
                  b = (k == 0) ? 0 : (k == 7) ? 255 : (k * 36 + 1);
                  @(negedge clk);
                  op_i = 4'(op); a_i = 8'(a); shamt_i = 3'(k);
                  use_imm_i = ((a + k) % 2 == 1);
                  if (use_imm_i) begin imm_i = 8'(b); b_reg_i = ~8'(b); end
                  else           begin b_reg_i = 8'(b); imm_i = ~8'(b); end
                  #1;
                  e = model(op, a, b, k, st, st);
                  case (op / 4)
                     0: rq = (op >= 2) ? "R2" : "R1";
                     1: rq = "R3";
                     2: rq = (k == 0) ? "R5" : "R4";
                     default: rq = "R7";
                  endcase
                  check(rq, "result", int'(result_o), e % 256);
                  check(rq, "c_next", int'(c_next_o), (e / 512) % 2);
                  check((op >= 12) ? "R7" : "R6", "z_next", int'(z_next_o), (e / 256) % 2);
               end
            end
         end
      end

      // R10: asynchronous reset clears set flags
      load_flags(0, 8'h80, 8'h80);
      #1 rst_n = 1'b0; #1;
      check("R10", "z_o async clear", int'(z_o), 0);
      check("R10", "c_o async clear", int'(c_o), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule